// File: doc/BRIEF.md
# Prescaled Event Sampling Controller

This block picks which complete events are copied into a small pool of sampling buffers, where a host or monitor can inspect them. Each event arrives as a one-cycle strobe carrying an 8-bit event type. The type must be enabled in a 256-entry enable vector. The events that pass this filter then go through an N-to-1 prescaler. An event that survives both is eligible. The decision for an event is made once and drives every output link, so all links sample the same events.

There are two capture modes. In random mode, an eligible event takes a buffer only when one is free, and is otherwise dropped and counted. In full-capture mode, every eligible event is captured. While all buffers are held, the block raises a link-full stall so the readout waits rather than losing events. Buffers are handed out lowest index first. The host returns a buffer by strobing a release with the buffer's index.

Top module: `evsamp_ctrl`

## Requirements
- R1: After reset, `buf_used` is 0, every `smp_take` bit is 0, `stall` is 0 and `skip_cnt` is 0.
- R2: An event whose type has a 0 in `cfg_type_mask` (bit position equals the type value) is never sampled and does not advance the prescaler.
- R3: Consider the mask-passing events that are accepted after reset. With `cfg_prescale` = N ≥ 2, the N-th, 2N-th, … of them are eligible. A value of 0 or 1 makes all of them eligible.
- R4: When an eligible event finds a free buffer, `smp_take` is high for one cycle after the event's clock edge. `smp_idx` gives the lowest-index buffer that was free before that edge, and the bit for that buffer is set in `buf_used` in the same cycle.
- R5: In random mode (`cfg_mode` = 0), an eligible event that finds no free buffer is not sampled, and `skip_cnt` rises by one on the next cycle. The counter saturates at all ones. `stall` never rises in random mode, and `skip_cnt` never changes in full-capture mode.
- R6: In full-capture mode (`cfg_mode` = 1), `stall` is high exactly while all four buffers are held. An event presented while `stall` is high is ignored: it is not sampled and it does not advance the prescaler.
- R7: A release clears the named buffer's bit in `buf_used` at the next edge. Releasing a buffer that is already free has no effect. An allocation in the same cycle as a release only sees the buffers that were free before the release.
- R8: All bits of `smp_take` carry the same value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | 0 = random capture, 1 = full capture |
| cfg_type_mask | input | 256 | Per-type enable, indexed by event type |
| cfg_prescale | input | 16 | Prescale ratio N (0 and 1 both mean every event) |
| ev_valid | input | 1 | One event presented this cycle |
| ev_type | input | 8 | Type of the presented event |
| rel_valid | input | 1 | Host releases a buffer this cycle |
| rel_idx | input | 2 | Index of the buffer being released |
| smp_take | output | 4 | Per-link sample strobe, identical on all links |
| smp_idx | output | 2 | Buffer assigned to the sampled event |
| buf_used | output | 4 | Buffer ownership bitmap |
| stall | output | 1 | Link-full stall in full-capture mode |
| skip_cnt | output | 16 | Eligible events dropped for lack of a buffer |

## Verification
`smp_take`, `smp_idx`, `buf_used` and `skip_cnt` change at the first rising edge after the cycle in which the event or release is presented. `stall` follows `buf_used` and `cfg_mode` within the same cycle. The bench changes its inputs 2 ns after each falling edge and runs a behavioural model at each rising edge. It compares every output with the model at the next falling edge, so each result is read exactly one edge after its stimulus. Directed phases count the samples and skips that R2, R3, R5, R6 and R7 predict, and a long random phase and a saturation phase follow them.

// File: rtl/evsamp_pkg.sv
package evsamp_pkg;

  typedef enum logic {
    SMP_RANDOM = 1'b0,
    SMP_FULL   = 1'b1
  } smp_mode_e;

endpackage

// File: rtl/evsamp_prescale.sv
module evsamp_prescale #(
  parameter int PS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [PS_W-1:0] limit,
  output logic            fire
);

  logic [PS_W-1:0] cnt_q, cnt_d;
  logic            at_limit;

  always_comb begin
    at_limit = (limit <= PS_W'(1)) || (cnt_q >= (limit - PS_W'(1)));
    fire     = step && at_limit;
    cnt_d    = cnt_q;
    if (step) begin
      cnt_d = at_limit ? '0 : (cnt_q + PS_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_d;
    end
  end

  AST_PS_STILL_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q)) else $error("prescale moved without a step"); // R2

endmodule

// File: rtl/evsamp_bufpool.sv
module evsamp_bufpool #(
  parameter int NBUF  = 4,
  parameter int IDX_W = $clog2(NBUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             rel_valid,
  input  logic [IDX_W-1:0] rel_idx,
  output logic             any_free,
  output logic [IDX_W-1:0] free_idx,
  output logic [NBUF-1:0]  used
);

  logic [NBUF-1:0] used_q, used_d;
  logic            upd_en;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    used_d = used_q;
    if (rel_valid && (32'(rel_idx) < NBUF)) begin
      used_d[rel_idx] = 1'b0;
    end
    if (alloc_req && any_free) begin
      used_d[free_idx] = 1'b1;
    end
    upd_en = rel_valid || (alloc_req && any_free);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (upd_en) begin
      used_q <= used_d;
    end
  end

  assign used = used_q;

  AST_POOL_ALLOC_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && any_free) |=> used_q[$past(free_idx)]) else $error("allocated buffer not marked"); // R4

  AST_POOL_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !(alloc_req && any_free) && (32'(rel_idx) < NBUF)) |=> !used_q[$past(rel_idx)])
    else $error("released buffer still marked"); // R7

endmodule

// File: rtl/evsamp_ctrl.sv
module evsamp_ctrl
  import evsamp_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int NBUF   = 4,
  parameter int NLINK  = 4,
  parameter int PS_W   = 16,
  parameter int SKIP_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_mode,
  input  logic [(1<<TYPE_W)-1:0]     cfg_type_mask,
  input  logic [PS_W-1:0]            cfg_prescale,
  input  logic                       ev_valid,
  input  logic [TYPE_W-1:0]          ev_type,
  input  logic                       rel_valid,
  input  logic [$clog2(NBUF)-1:0]    rel_idx,
  output logic [NLINK-1:0]           smp_take,
  output logic [$clog2(NBUF)-1:0]    smp_idx,
  output logic [NBUF-1:0]            buf_used,
  output logic                       stall,
  output logic [SKIP_W-1:0]          skip_cnt
);

  localparam int IDX_W = $clog2(NBUF);

  smp_mode_e         mode;
  logic              accept, pass, fire, take, skip;
  logic              any_free;
  logic [IDX_W-1:0]  free_idx;
  logic              take_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic              skip_en;

  assign mode = smp_mode_e'(cfg_mode);

  always_comb begin
    stall   = (mode == SMP_FULL) && (&buf_used);
    accept  = ev_valid && !stall;
    pass    = accept && cfg_type_mask[ev_type];
    take    = fire && any_free;
    skip    = fire && !any_free && (mode == SMP_RANDOM);
    idx_d   = take ? free_idx : idx_q;
    skip_en = skip && (skip_q != '1);
    skip_d  = skip_q + SKIP_W'(1);
  end

  evsamp_prescale #(.PS_W(PS_W)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (pass),
    .limit (cfg_prescale),
    .fire  (fire)
  );

  evsamp_bufpool #(.NBUF(NBUF), .IDX_W(IDX_W)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (take),
    .rel_valid (rel_valid),
    .rel_idx   (rel_idx),
    .any_free  (any_free),
    .free_idx  (free_idx),
    .used      (buf_used)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      take_q <= take;
      if (take) begin
        idx_q <= idx_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= '0;
    end else if (skip_en) begin
      skip_q <= skip_d;
    end
  end

  for (genvar l = 0; l < NLINK; l++) begin : g_link
    assign smp_take[l] = take_q;
  end

  assign smp_idx  = idx_q;
  assign skip_cnt = skip_q;

  AST_STALL_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !take_q) else $error("sample taken while stalled"); // R6

  AST_TAKE_OWNS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> buf_used[idx_q]) else $error("sampled buffer not held"); // R4

  AST_SKIP_ONLY_RANDOM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SMP_FULL) |=> $stable(skip_cnt)) else $error("skip counted in full mode"); // R5

  AST_MASKED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !cfg_type_mask[ev_type] && !rel_valid) |=> (!take_q && $stable(buf_used)))
    else $error("masked event sampled"); // R2

endmodule

// File: tb/evsamp_ctrl_bench.sv
module evsamp_ctrl_bench;

  logic         clk;
  logic         rst_n;
  logic         cfg_mode;
  logic [255:0] cfg_type_mask;
  logic [15:0]  cfg_prescale;
  logic         ev_valid;
  logic [7:0]   ev_type;
  logic         rel_valid;
  logic [1:0]   rel_idx;
  logic [3:0]   smp_take;
  logic [1:0]   smp_idx;
  logic [3:0]   buf_used;
  logic         stall;
  logic [15:0]  skip_cnt;

  int n_checks = 0;
  int n_bad    = 0;
  int n_take   = 0;
  bit cmp_on   = 0;

  // behavioural reference state
  bit m_used [4];
  int m_cnt;
  int m_skip;
  bit m_take;
  int m_idx;

  evsamp_ctrl u_evsamp_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_type_mask (cfg_type_mask),
    .cfg_prescale  (cfg_prescale),
    .ev_valid      (ev_valid),
    .ev_type       (ev_type),
    .rel_valid     (rel_valid),
    .rel_idx       (rel_idx),
    .smp_take      (smp_take),
    .smp_idx       (smp_idx),
    .buf_used      (buf_used),
    .stall         (stall),
    .skip_cnt      (skip_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_all_used();
    return m_used[0] && m_used[1] && m_used[2] && m_used[3];
  endfunction

  function automatic int m_used_vec();
    int v = 0;
    for (int i = 0; i < 4; i++) if (m_used[i]) v += (1 << i);
    return v;
  endfunction

  // reference model, evaluated at each rising edge on the inputs held since 2 ns after the falling edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_used[i] = 0;
      m_cnt = 0; m_skip = 0; m_take = 0; m_idx = 0;
    end else begin
      bit st, fired;
      int lim, f;
      st = cfg_mode && m_all_used();
      fired = 0;
      if (ev_valid && !st && cfg_type_mask[ev_type]) begin
        lim = (cfg_prescale <= 1) ? 1 : int'(cfg_prescale);
        if (m_cnt >= lim - 1) begin fired = 1; m_cnt = 0; end
        else m_cnt++;
      end
      f = -1;
      for (int i = 3; i >= 0; i--) if (!m_used[i]) f = i;
      m_take = 0;
      if (fired) begin
        if (f >= 0) begin m_take = 1; m_idx = f; end
        else if (!cfg_mode && m_skip < 65535) m_skip++;
      end
      if (rel_valid) m_used[rel_idx] = 0;
      if (m_take) m_used[m_idx] = 1;
    end
  end

  // comparison at every falling edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check("R4 take", int'(smp_take[0]), int'(m_take));
      if (m_take) check("R4 idx", int'(smp_idx), m_idx);
      check("R8 links agree", int'(smp_take == 4'b0000 || smp_take == 4'b1111), 1);
      check("R7 buf_used", int'(buf_used), m_used_vec());
      check("R6 stall", int'(stall), int'(cfg_mode && m_all_used()));
      check("R5 skip_cnt", int'(skip_cnt), m_skip);
      if (smp_take[0]) n_take++;
    end
  end

  task automatic cyc(input bit ev, input int ty, input bit rv, input int ri);
    @(negedge clk);
    #2;
    ev_valid  = ev;
    ev_type   = 8'(ty);
    rel_valid = rv;
    rel_idx   = 2'(ri);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic free_all();
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, i);
    idle(1);
  endtask

  initial begin
    #4_000_000;
    n_checks++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    int sk;
    rst_n = 0; cfg_mode = 0; cfg_type_mask = '0; cfg_prescale = 16'd1;
    ev_valid = 0; ev_type = 0; rel_valid = 0; rel_idx = 0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 buf_used", int'(buf_used), 0);
    check("R1 smp_take", int'(smp_take), 0);
    check("R1 stall", int'(stall), 0);
    check("R1 skip_cnt", int'(skip_cnt), 0);
    cmp_on = 1;

    // R2 mask filtering
    cfg_type_mask[5] = 1'b1; cfg_type_mask[200] = 1'b1;
    n_take = 0;
    for (int i = 0; i < 4; i++) cyc(1, 7, 0, 0);
    idle(2);
    check("R2 masked takes", n_take, 0);
    cyc(1, 5, 0, 0);
    cyc(1, 200, 0, 0);
    idle(2);
    check("R2 enabled takes", n_take, 2);
    free_all();

    // R3 prescale of 3, masked events interleaved
    cfg_prescale = 16'd3;
    n_take = 0;
    for (int i = 0; i < 9; i++) begin cyc(1, 5, 0, 0); cyc(1, 9, 0, 0); end
    idle(2);
    check("R3 prescale 3 takes", n_take, 3);
    free_all();
    cfg_prescale = 16'd0;
    n_take = 0;
    for (int i = 0; i < 3; i++) cyc(1, 200, 0, 0);
    idle(2);
    check("R3 prescale 0 takes", n_take, 3);
    free_all();

    // R5 random mode overflow
    cfg_prescale = 16'd1;
    sk = int'(skip_cnt);
    for (int i = 0; i < 6; i++) cyc(1, 5, 0, 0);
    idle(2);
    check("R5 skipped", int'(skip_cnt) - sk, 2);
    check("R5 no stall in random", int'(stall), 0);

    // R7 release and allocate in the same cycle: pool still seen full
    cyc(1, 5, 1, 2);
    idle(1);
    check("R7 same-cycle skip", int'(skip_cnt) - sk, 3);
    cyc(1, 5, 0, 0);
    idle(1);
    check("R7 freed buffer reused", int'(smp_idx), 2);
    cyc(0, 0, 1, 2);
    cyc(0, 0, 1, 2);
    idle(1);
    check("R7 double release", int'(buf_used), 4'b1011);
    cyc(1, 5, 0, 0);
    idle(1);

    // R6 full-capture stall
    cfg_mode = 1'b1;
    idle(1);
    check("R6 stall while full", int'(stall), 1);
    n_take = 0;
    sk = int'(skip_cnt);
    for (int i = 0; i < 5; i++) cyc(1, 5, 0, 0);
    idle(2);
    check("R6 ignored takes", n_take, 0);
    check("R6 skip frozen", int'(skip_cnt), sk);
    cyc(0, 0, 1, 1);
    idle(1);
    check("R6 stall drops", int'(stall), 0);
    cfg_prescale = 16'd2;
    cyc(1, 5, 0, 0);
    cyc(1, 5, 0, 0);
    idle(1);
    check("R6 refill idx", int'(smp_idx), 1);
    check("R6 stall again", int'(stall), 1);
    free_all();

    // randomized phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        cfg_mode = 1'($urandom_range(0, 1));
        cfg_prescale = 16'($urandom_range(0, 4));
        for (int b = 0; b < 256; b++) cfg_type_mask[b] = 1'($urandom_range(0, 1));
      end
      cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
          ($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)));
    end
    idle(2);

    // R5 saturation of skip counter
    cfg_mode = 1'b0; cfg_prescale = 16'd1; cfg_type_mask = '1;
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0);
    for (int i = 0; i < 65600; i++) cyc(1, 3, 0, 0);
    idle(2);
    check("R5 saturated", int'(skip_cnt), 65535);

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule